// File: doc/BRIEF.md
# Receive Idle Timeout

This block watches the receive side of a FIFO-based serial port and reports when the line has gone quiet while bytes are still waiting. Each time a byte is written into the receive FIFO, a countdown restarts. The countdown length is a 4-bit multiplier times one character time. The character time, in bit periods, follows from the current frame format. The countdown advances once per incoming baud bit tick.

When the countdown runs out, the block checks whether reporting is allowed. It reports if the data-ready flag is high, or if the empty-FIFO override input is set. In that case it raises a sticky timeout flag and emits a one-cycle receive-interrupt event. Software clears the flag by writing a 1 into the flag's bit position.

A pending countdown is dropped in two cases: the enable input goes low, or the receive trigger level is reached. Baud-rate generation and interrupt masking belong to neighbouring blocks.

Top module: `rx_idle_timeout`

## Requirements
- R1: While reset is high and in the first cycle after it, `timeout_flag` and `rx_irq_pulse` are 0.
- R2: After a byte is stored with the enable high and a non-zero multiplier M, the Nth following `baud_tick` ends the countdown, where N = M × W. When the countdown ends and reporting is allowed, `rx_irq_pulse` and `timeout_flag` are both 1 in the cycle after that tick is sampled.
- R3: W, the character length in bit periods, is data bits + stop bits + 1 start bit. Data bits = `frame_dsel` + 5 (codes 0..3 give 5..8 bits). Stop bits = 2 when `frame_two_stop` is 1, else 1. W is captured when the countdown is armed.
- R4: A byte stored while a countdown runs restarts it from the full length. A store in the same cycle as the final tick prevents expiry.
- R5: Driving `to_enable` low drops any pending countdown. A byte stored while `to_enable` is low arms nothing.
- R6: `trig_hit` drops any pending countdown. If it coincides with `rx_store`, the countdown is not armed.
- R7: At expiry, nothing is reported unless `data_ready` or `empty_override` is 1 in the cycle of the final tick. Either one alone is enough.
- R8: A cycle with `stat_wr` = 1 and `stat_wr_clr` = 1 clears `timeout_flag`. With `stat_wr_clr` = 0 the flag is unchanged. The flag falls only through such a write.
- R9: A multiplier of 0 at the time of the store never produces an expiry, however many ticks follow.
- R10: `rx_irq_pulse` lasts exactly one cycle. An expiry in the same cycle as a clearing write leaves `timeout_flag` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_store | input | 1 | A received byte is written into the FIFO this cycle |
| trig_hit | input | 1 | Receive trigger level reached; cancels the countdown |
| to_enable | input | 1 | Timeout function enable |
| to_mult | input | 4 | Countdown length in characters |
| frame_dsel | input | 2 | Data-bit code (bits = code + 5) |
| frame_two_stop | input | 1 | 1 selects two stop bits |
| baud_tick | input | 1 | One pulse per bit period |
| data_ready | input | 1 | Receive data is waiting |
| empty_override | input | 1 | Allow reporting even with no data waiting |
| stat_wr | input | 1 | Status write strobe |
| stat_wr_clr | input | 1 | Written value of the timeout bit; 1 clears |
| timeout_flag | output | 1 | Sticky timeout status |
| rx_irq_pulse | output | 1 | One-cycle receive interrupt event |

## Verification
Both results have a latency of one register: the cycle in which the last required `baud_tick` is sampled updates `rx_irq_pulse` and `timeout_flag` at that clock edge. Each clearing write takes effect at the edge that samples it. The bench drives every strobe for one cycle from the falling edge. It reads the outputs at the next falling edge, halfway between the consuming edge and the one after it. Each expiry case is checked twice: once just before the final tick, where both outputs must be 0, and once right after it. The cycle after that is checked again to confirm the event has ended.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    localparam int MULT_W     = 4;
    localparam int DSEL_W     = 2;
    localparam int WLEN_W     = 4;
    localparam int DATA_BASE  = 5;
    localparam int RESET_WLEN = 10;

    typedef struct packed {
        logic [DSEL_W-1:0] dsel;
        logic              two_stop;
    } frame_t;

    typedef enum logic {
        CD_IDLE = 1'b0,
        CD_RUN  = 1'b1
    } cd_state_e;

    // character length in bit periods: start + data + stop
    function automatic logic [WLEN_W-1:0] word_bits(frame_t f);
        logic [WLEN_W-1:0] d;
        logic [WLEN_W-1:0] s;
        d = WLEN_W'(f.dsel);
        s = f.two_stop ? WLEN_W'(2) : WLEN_W'(1);
        return WLEN_W'(DATA_BASE + 1) + d + s;
    endfunction

endpackage

// File: rtl/rxto_frame.sv
module rxto_frame
    import rxto_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  frame_t            frm,
    output logic [WLEN_W-1:0] wlen
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wlen <= WLEN_W'(RESET_WLEN);
        end else if (load) begin
            wlen <= word_bits(frm);
        end
    end

endmodule

// File: rtl/rxto_countdown.sv
module rxto_countdown
    import rxto_pkg::*;
#(
    parameter int CNT_MULT_W = MULT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  arm,
    input  logic                  cancel,
    input  logic                  tick,
    input  logic [WLEN_W-1:0]     wlen,
    input  logic [CNT_MULT_W-1:0] mult,
    output logic                  expire
);

    cd_state_e             state;
    logic [WLEN_W-1:0]     bit_cnt;
    logic [CNT_MULT_W-1:0] words_left;
    logic                  last_bit;
    logic                  last_word;

    assign last_bit  = (bit_cnt == wlen - WLEN_W'(1));
    assign last_word = (words_left == CNT_MULT_W'(1));
    assign expire    = (state == CD_RUN) && tick && !cancel && !arm
                       && last_bit && last_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CD_IDLE;
            bit_cnt    <= '0;
            words_left <= '0;
        end else if (cancel) begin
            state <= CD_IDLE;
        end else if (arm) begin
            bit_cnt    <= '0;
            words_left <= mult;
            state      <= (mult != '0) ? CD_RUN : CD_IDLE;
        end else if (state == CD_RUN && tick) begin
            if (last_bit) begin
                bit_cnt <= '0;
                if (last_word) begin
                    state <= CD_IDLE;
                end else begin
                    words_left <= words_left - CNT_MULT_W'(1);
                end
            end else begin
                bit_cnt <= bit_cnt + WLEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/rxto_report.sv
module rxto_report (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic qualify,
    input  logic clr_wr,
    output logic flag,
    output logic pulse
);

    logic fire;

    assign fire = expire && qualify;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
            if (fire) begin
                flag <= 1'b1;
            end else if (clr_wr) begin
                flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rxto_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_store,
    input  logic              trig_hit,
    input  logic              to_enable,
    input  logic [MULT_W-1:0] to_mult,
    input  logic [DSEL_W-1:0] frame_dsel,
    input  logic              frame_two_stop,
    input  logic              baud_tick,
    input  logic              data_ready,
    input  logic              empty_override,
    input  logic              stat_wr,
    input  logic              stat_wr_clr,
    output logic              timeout_flag,
    output logic              rx_irq_pulse
);

    frame_t            frm;
    logic [WLEN_W-1:0] wlen;
    logic              cancel;
    logic              arm;
    logic              expire;

    assign frm.dsel     = frame_dsel;
    assign frm.two_stop = frame_two_stop;
    assign cancel       = !to_enable || trig_hit;
    assign arm          = rx_store && !cancel;

    rxto_frame u_frame (
        .clk  (clk),
        .rst  (rst),
        .load (arm),
        .frm  (frm),
        .wlen (wlen)
    );

    rxto_countdown #(.CNT_MULT_W(MULT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm),
        .cancel (cancel),
        .tick   (baud_tick),
        .wlen   (wlen),
        .mult   (to_mult),
        .expire (expire)
    );

    rxto_report u_report (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .qualify (data_ready || empty_override),
        .clr_wr  (stat_wr && stat_wr_clr),
        .flag    (timeout_flag),
        .pulse   (rx_irq_pulse)
    );

endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk (
    input logic clk,
    input logic rst,
    input logic rx_store,
    input logic trig_hit,
    input logic to_enable,
    input logic data_ready,
    input logic empty_override,
    input logic stat_wr,
    input logic stat_wr_clr,
    input logic timeout_flag,
    input logic rx_irq_pulse
);

    // R2
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq_pulse |-> timeout_flag);

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq_pulse |=> !rx_irq_pulse);

    // R7
    pulse_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq_pulse |-> $past(data_ready || empty_override));

    // R5
    pulse_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq_pulse |-> $past(to_enable));

    // R6
    pulse_no_trig_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq_pulse |-> $past(!trig_hit));

    // R4
    pulse_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq_pulse |-> $past(!rx_store));

    // R8
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(timeout_flag) |-> $past(stat_wr && stat_wr_clr));

    // R2
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> rx_irq_pulse);

endmodule

bind rx_idle_timeout rx_idle_timeout_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .rx_store       (rx_store),
    .trig_hit       (trig_hit),
    .to_enable      (to_enable),
    .data_ready     (data_ready),
    .empty_override (empty_override),
    .stat_wr        (stat_wr),
    .stat_wr_clr    (stat_wr_clr),
    .timeout_flag   (timeout_flag),
    .rx_irq_pulse   (rx_irq_pulse)
);

// File: tb/rx_idle_timeout_test.sv
`timescale 1ns/1ps
module rx_idle_timeout_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_store = 1'b0;
    logic       trig_hit = 1'b0;
    logic       to_enable = 1'b1;
    logic [3:0] to_mult = 4'd1;
    logic [1:0] frame_dsel = 2'd0;
    logic       frame_two_stop = 1'b0;
    logic       baud_tick = 1'b0;
    logic       data_ready = 1'b1;
    logic       empty_override = 1'b0;
    logic       stat_wr = 1'b0;
    logic       stat_wr_clr = 1'b0;
    logic       timeout_flag;
    logic       rx_irq_pulse;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    rx_idle_timeout uut (
        .clk(clk), .rst(rst), .rx_store(rx_store), .trig_hit(trig_hit),
        .to_enable(to_enable), .to_mult(to_mult), .frame_dsel(frame_dsel),
        .frame_two_stop(frame_two_stop), .baud_tick(baud_tick),
        .data_ready(data_ready), .empty_override(empty_override),
        .stat_wr(stat_wr), .stat_wr_clr(stat_wr_clr),
        .timeout_flag(timeout_flag), .rx_irq_pulse(rx_irq_pulse)
    );

    // fields: dsel[9:8] two_stop[7] mult[6:3] dr[2] ovr[1] expect[0]
    localparam int NVEC = 6;
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 4'd1,  1'b1, 1'b0, 1'b1},
        {2'd3, 1'b1, 4'd2,  1'b1, 1'b0, 1'b1},
        {2'd1, 1'b0, 4'd3,  1'b0, 1'b1, 1'b1},
        {2'd2, 1'b1, 4'd1,  1'b0, 1'b0, 1'b0},
        {2'd3, 1'b0, 4'd15, 1'b1, 1'b0, 1'b1},
        {2'd0, 1'b1, 4'd4,  1'b1, 1'b1, 1'b1}
    };

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic store();
        rx_store = 1'b1;
        @(negedge clk);
        rx_store = 1'b0;
    endtask

    // each tick preceded by one idle cycle; ends just after the consuming edge
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    endtask

    task automatic clear_flag(logic val);
        stat_wr = 1'b1;
        stat_wr_clr = val;
        @(negedge clk);
        stat_wr = 1'b0;
        stat_wr_clr = 1'b0;
    endtask

    function automatic int wbits(logic [1:0] ds, logic ts);
        return int'(ds) + 5 + (ts ? 2 : 1) + 1;
    endfunction

    task automatic fire_once(int total);
        store();
        ticks(total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 flag in reset", timeout_flag, 1'b0);
        check("R1 pulse in reset", rx_irq_pulse, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 flag after reset", timeout_flag, 1'b0);
        check("R1 pulse after reset", rx_irq_pulse, 1'b0);

        // table walk: R2 / R3 / R7 / R8 / R10
        for (int v = 0; v < NVEC; v++) begin
            int total;
            logic ex;
            frame_dsel     = VEC[v][9:8];
            frame_two_stop = VEC[v][7];
            to_mult        = VEC[v][6:3];
            data_ready     = VEC[v][2];
            empty_override = VEC[v][1];
            ex             = VEC[v][0];
            total = wbits(VEC[v][9:8], VEC[v][7]) * int'(VEC[v][6:3]);
            store();
            ticks(total - 1);
            check("R3 no pulse before final tick", rx_irq_pulse, 1'b0);
            check("R3 no flag before final tick", timeout_flag, 1'b0);
            ticks(1);
            check("R2/R7 pulse at expiry", rx_irq_pulse, ex);
            check("R2/R7 flag at expiry", timeout_flag, ex);
            @(negedge clk);
            check("R10 pulse one cycle", rx_irq_pulse, 1'b0);
            clear_flag(1'b1);
            check("R8 flag cleared", timeout_flag, 1'b0);
        end

        data_ready = 1'b1;
        empty_override = 1'b0;
        frame_dsel = 2'd0;
        frame_two_stop = 1'b0;
        to_mult = 4'd1;   // W = 7, total 7

        // R4 restart
        store();
        ticks(5);
        store();
        ticks(6);
        check("R4 no pulse after restart", rx_irq_pulse, 1'b0);
        ticks(1);
        check("R4 pulse after full length", rx_irq_pulse, 1'b1);
        clear_flag(1'b1);

        // R8 write of zero keeps flag
        fire_once(7);
        clear_flag(1'b0);
        check("R8 zero write keeps flag", timeout_flag, 1'b1);
        clear_flag(1'b1);
        check("R8 one write clears flag", timeout_flag, 1'b0);

        // R10 set wins over same-cycle clear
        store();
        ticks(6);
        @(negedge clk);
        baud_tick = 1'b1;
        stat_wr = 1'b1;
        stat_wr_clr = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        stat_wr = 1'b0;
        stat_wr_clr = 1'b0;
        check("R10 set beats clear", timeout_flag, 1'b1);
        clear_flag(1'b1);

        // R5 disable cancels
        store();
        ticks(3);
        to_enable = 1'b0;
        @(negedge clk);
        to_enable = 1'b1;
        ticks(20);
        check("R5 disable cancels", timeout_flag, 1'b0);
        to_enable = 1'b0;
        store();
        to_enable = 1'b1;
        ticks(20);
        check("R5 store while disabled", timeout_flag, 1'b0);

        // R6 trigger cancels
        store();
        ticks(2);
        trig_hit = 1'b1;
        @(negedge clk);
        trig_hit = 1'b0;
        ticks(20);
        check("R6 trigger cancels", timeout_flag, 1'b0);
        trig_hit = 1'b1;
        store();
        trig_hit = 1'b0;
        ticks(20);
        check("R6 trigger beats store", timeout_flag, 1'b0);

        // R4 store on final tick blocks expiry
        store();
        ticks(6);
        @(negedge clk);
        baud_tick = 1'b1;
        rx_store = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        rx_store = 1'b0;
        check("R4 store on last tick", rx_irq_pulse, 1'b0);
        trig_hit = 1'b1;
        @(negedge clk);
        trig_hit = 1'b0;

        // R9 zero multiplier
        to_mult = 4'd0;
        store();
        ticks(40);
        check("R9 zero multiplier", timeout_flag, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule